// File: doc/BRIEF.md
# Lane Mode Pattern Gather and Branch Test

This block keeps an 8-bit mode register for every lane of a 64-lane SIMD array, with bit 0 of each register serving as that lane's enable. Lane enables can be forced on everywhere at once, cleared over a contiguous span of lanes, or rewritten lane by lane along with the other seven mode bits.

On a gather command, the block picks one bit position from 0 to 7. It copies that bit from every lane into a 64-bit pattern register in the control unit, with lane i landing in pattern bit i. A branch-test command then asks whether that pattern is all zeros or has any bit set, and gets back a taken or not-taken answer in the same cycle. Control code can therefore steer its own instruction stream by the state of the whole array.

Top module: `mode_gather_branch`

## Requirements
- R1: After reset every lane's mode register holds 8'h01 (all lanes enabled), the pattern register is all zeros, and a branch-on-nonzero test reports not taken.
- R2: With `wr_en` high, lane `wr_lane` takes `wr_data` as its mode register at the next clock edge. All other lanes keep their value.
- R3: With `en_all` high, bit 0 of every lane's mode register is set at the next clock edge. Bits 7..1 are not changed.
- R4: With `dis_en` high, bit 0 is cleared at the next clock edge in every lane from `dis_lo` to `dis_hi` inclusive. Lanes outside that span are not changed. If `dis_lo` > `dis_hi`, no lane changes.
- R5: When commands coincide in one cycle, a per-lane write wins for its lane over both range commands. A range disable wins over enable-all for lanes inside its span.
- R6: With `gather_en` high, the pattern register takes bit `gather_sel` of each lane's mode register, as held before the edge, at the next clock edge. Lane i goes to pattern bit i. Without `gather_en` the pattern holds.
- R7: `br_taken` is combinational and is high only while `br_en` is high. With `br_nz` = 0 it is high when the pattern is all zeros. With `br_nz` = 1 it is high when any pattern bit is set. A test in the cycle after a gather sees the newly captured pattern. A test in the gather cycle itself sees the previous one.
- R8: `lane_active[i]` always shows bit 0 of lane i's mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a full mode register |
| wr_lane | input | 6 | Lane written |
| wr_data | input | 8 | Mode value written |
| en_all | input | 1 | Set enable bit in all lanes |
| dis_en | input | 1 | Clear enable bit over a lane span |
| dis_lo | input | 6 | First lane of span |
| dis_hi | input | 6 | Last lane of span |
| gather_en | input | 1 | Capture one mode bit per lane into the pattern |
| gather_sel | input | 3 | Mode bit position gathered |
| br_en | input | 1 | Branch test request |
| br_nz | input | 1 | 0: taken on zero pattern, 1: taken on nonzero |
| pattern | output | 64 | Gathered pattern register |
| lane_active | output | 64 | Enable bit of each lane |
| br_taken | output | 1 | Branch test result |

## Verification
The gather is exercised with patterns of several shapes: a single bit at lane 5, a single bit at lane 63, every lane but one, all lanes, none, and a hole of eight lanes. These shapes separate a swapped lane order, a wrong bit select and an off-by-one span edge. Branch tests are run on both zero and nonzero patterns under each polarity, and once in the same cycle as a gather, which separates a registered pattern from a pass-through. Coinciding commands and a reversed span check the priority rules and the empty-span case.

// File: rtl/mode_gather_branch.sv
module mode_gather_branch #(
  parameter int LANES    = 64,
  parameter int MBITS    = 8,
  parameter int EN_BIT   = 0,
  parameter logic [7:0] RST_MODE = 8'h01,
  localparam int LW = $clog2(LANES),
  localparam int SW = $clog2(MBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_lane,
  input  logic [MBITS-1:0] wr_data,
  input  logic             en_all,
  input  logic             dis_en,
  input  logic [LW-1:0]    dis_lo,
  input  logic [LW-1:0]    dis_hi,
  input  logic             gather_en,
  input  logic [SW-1:0]    gather_sel,
  input  logic             br_en,
  input  logic             br_nz,
  output logic [LANES-1:0] pattern,
  output logic [LANES-1:0] lane_active,
  output logic             br_taken
);

  logic [MBITS-1:0] mode_q [LANES];
  logic [LANES-1:0] gathered;
  logic [LANES-1:0] pat_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_span;
    logic [MBITS-1:0] mode_d;

    assign in_span = dis_en && (LW'(i) >= dis_lo) && (LW'(i) <= dis_hi);

    always_comb begin
      mode_d = mode_q[i];
      if (en_all)  mode_d[EN_BIT] = 1'b1;
      if (in_span) mode_d[EN_BIT] = 1'b0;
      if (wr_en && wr_lane == LW'(i)) mode_d = wr_data;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[i] <= RST_MODE[MBITS-1:0];
      else        mode_q[i] <= mode_d;
    end

    assign gathered[i]    = mode_q[i][gather_sel];
    assign lane_active[i] = mode_q[i][EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         pat_q <= '0;
    else if (gather_en) pat_q <= gathered;
  end

  assign pattern  = pat_q;
  assign br_taken = br_en && (br_nz ? (|pat_q) : ~(|pat_q));

  AST_PAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !gather_en |=> $stable(pattern)) else $error("pattern moved"); // R6

  AST_TAKEN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> br_en) else $error("taken without request"); // R7

  AST_ENALL_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    en_all && !dis_en && !wr_en |=> &lane_active) else $error("enable-all missed a lane"); // R3

  AST_DIS_FULL_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en && dis_lo == '0 && dis_hi == LW'(LANES-1) && !wr_en |=> lane_active == '0)
    else $error("full disable left a lane on"); // R4

  AST_DIS_EMPTY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    dis_en && dis_lo > dis_hi && !en_all && !wr_en |=> $stable(lane_active))
    else $error("reversed span changed lanes"); // R4

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lane_active[$past(wr_lane)] == $past(wr_data[EN_BIT]))
    else $error("write lost"); // R5

endmodule

// File: tb/tb_mode_gather_branch.sv
module tb_mode_gather_branch;
  localparam int PERIOD = 10;
  localparam int OP_WR = 1, OP_ALL = 2, OP_DIS = 3, OP_GAT = 4, OP_BZ = 5, OP_BNZ = 6;
  localparam int NV = 18;
  // {op[3:0], a[7:0], b[5:0], c[5:0]}
  localparam logic [23:0] VEC [NV] = '{
    {4'd1, 8'h04, 6'd5,  6'd0},
    {4'd4, 8'd2,  6'd0,  6'd0},
    {4'd6, 8'd0,  6'd0,  6'd0},
    {4'd5, 8'd0,  6'd0,  6'd0},
    {4'd4, 8'd0,  6'd0,  6'd0},
    {4'd3, 8'd0,  6'd0,  6'd63},
    {4'd4, 8'd0,  6'd0,  6'd0},
    {4'd5, 8'd0,  6'd0,  6'd0},
    {4'd2, 8'd0,  6'd0,  6'd0},
    {4'd4, 8'd0,  6'd0,  6'd0},
    {4'd6, 8'd0,  6'd0,  6'd0},
    {4'd3, 8'd0,  6'd8,  6'd15},
    {4'd4, 8'd0,  6'd0,  6'd0},
    {4'd1, 8'h80, 6'd63, 6'd0},
    {4'd4, 8'd7,  6'd0,  6'd0},
    {4'd6, 8'd0,  6'd0,  6'd0},
    {4'd4, 8'd6,  6'd0,  6'd0},
    {4'd6, 8'd0,  6'd0,  6'd0}
  };

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, en_all = 0, dis_en = 0, gather_en = 0, br_en = 0, br_nz = 0;
  logic [5:0] wr_lane = 0, dis_lo = 0, dis_hi = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] gather_sel = 0;
  logic [63:0] pattern, lane_active;
  logic br_taken;

  int checks = 0, fails = 0;
  logic [7:0] m [64];
  logic [63:0] mpat;

  always #(PERIOD/2) clk = ~clk;

  mode_gather_branch dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model_active();
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = m[i][0];
    return r;
  endfunction

  task automatic apply(input int op, input logic [7:0] a, input logic [5:0] b, input logic [5:0] c);
    @(negedge clk);
    case (op)
      OP_WR:  begin wr_en = 1; wr_lane = b; wr_data = a; end
      OP_ALL: en_all = 1;
      OP_DIS: begin dis_en = 1; dis_lo = b; dis_hi = c; end
      OP_GAT: begin gather_en = 1; gather_sel = a[2:0]; end
      default: begin br_en = 1; br_nz = (op == OP_BNZ); end
    endcase
    if (op == OP_BZ || op == OP_BNZ) begin
      #1;
      chk("R7", {63'd0, br_taken}, {63'd0, (op == OP_BNZ) ? (mpat != 0) : (mpat == 0)});
    end
    @(negedge clk);
    wr_en = 0; en_all = 0; dis_en = 0; gather_en = 0; br_en = 0;
    case (op)
      OP_WR:  m[b] = a;
      OP_ALL: for (int i = 0; i < 64; i++) m[i][0] = 1'b1;
      OP_DIS: for (int i = 0; i < 64; i++) if (i >= b && i <= c) m[i][0] = 1'b0;
      OP_GAT: for (int i = 0; i < 64; i++) mpat[i] = m[i][a[2:0]];
      default: ;
    endcase
    if (op == OP_GAT) chk("R6", pattern, mpat);
    if (op == OP_WR || op == OP_ALL || op == OP_DIS)
      chk(op == OP_WR ? "R2" : op == OP_ALL ? "R3" : "R4", lane_active, model_active());
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m[i] = 8'h01;
    mpat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", pattern, 64'd0);
    chk("R8", lane_active, {64{1'b1}});
    br_en = 1; br_nz = 1; #1;
    chk("R1", {63'd0, br_taken}, 64'd0);
    @(negedge clk); br_en = 0;

    for (int k = 0; k < NV; k++)
      apply(int'(VEC[k][23:20]), VEC[k][19:12], VEC[k][11:6], VEC[k][5:0]);

    // R5 coinciding commands
    @(negedge clk);
    en_all = 1; dis_en = 1; dis_lo = 6'd0; dis_hi = 6'd3;
    wr_en = 1; wr_lane = 6'd2; wr_data = 8'h01;
    @(negedge clk);
    en_all = 0; dis_en = 0; wr_en = 0;
    for (int i = 0; i < 64; i++) m[i][0] = 1'b1;
    for (int i = 0; i < 4; i++) m[i][0] = 1'b0;
    m[2] = 8'h01;
    chk("R5", lane_active, model_active());

    // R4 reversed span is ignored
    apply(OP_DIS, 8'h00, 6'd10, 6'd5);
    chk("R4", lane_active, 64'hFFFF_FFFF_FFFF_FFF4);

    // R7 test during gather sees old pattern, next cycle sees new
    apply(OP_GAT, 8'd6, 6'd0, 6'd0);
    @(negedge clk);
    gather_en = 1; gather_sel = 3'd0; br_en = 1; br_nz = 0; #1;
    chk("R7", {63'd0, br_taken}, 64'd1);
    @(negedge clk);
    gather_en = 0; #1;
    chk("R7", {63'd0, br_taken}, 64'd0);
    chk("R6", pattern, model_active());
    @(negedge clk); br_en = 0;

    // R6 pattern holds without gather, R8 after write
    apply(OP_WR, 8'hFE, 6'd40, 6'd0);
    chk("R6", pattern, 64'hFFFF_FFFF_FFFF_FFF4);
    chk("R8", lane_active[40], 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule